// File: doc/BRIEF.md
# Serial Register Port with Latched Status and Event Counters

This block is the host-facing slave of a line monitor. It sits on a chip-select framed serial link with clock, data-in and data-out pins, and gives access to eleven byte-wide registers. These are a 16-bit event counter split into two bytes, three 8-bit event counters, two latched status bytes, two interrupt mask bytes and two control bytes. The line-side logic outside this block supplies one increment strobe per counter and set and condition-present vectors for the status bits. It takes back the control bytes.

Each access starts with a command byte that selects read or write and a register address. One or more data bytes follow. When the burst flag is set with address zero, successive bytes walk up through the register map until chip select rises. Counters count up from a host-written preset and stop at all-ones. An event that arrives at saturation latches a saturation status bit. A control bit can clear every counter when the host reads. The interrupt output is low while any status bit is latched and enabled by its mask.

The serial pins are sampled on the block clock. That clock must run well above the serial clock, at least six block cycles per serial half-period.

Top module: `sreg_port`

## Requirements
- R1: Bits travel LSB first. Data-in is taken on the rising serial clock edge. Data-out changes after the falling edge, and read bit i can be sampled before the next rising edge.
- R2: Command byte: bit 0 = 1 means read and 0 means write; bits 4:1 give the address; bit 7 is the burst flag. Addresses: 0 wide counter low, 1 wide counter high, 2..4 narrow counters 0..2, 5 status A, 6 mask A, 7 status B, 8 mask B, 9 control A, 10 control B.
- R3: A burst is active only when bit 7 is set and the address is 0. Data bytes then go to or come from addresses 0, 1, 2, ... in order. Otherwise only one data byte is transferred and later bytes are ignored, with data-out not driven.
- R4: Chip select high aborts a transfer, and a partly shifted byte is never written. The data-out enable is low while chip select is high, during the command byte and during writes.
- R5: A status bit latches on its set strobe. A non-burst read of its byte returns the latched value and then clears each bit whose condition-present input is low. Status bytes ignore writes.
- R6: A burst read leaves the status bits unchanged.
- R7: With control A bit 4 set, every read command clears all four counters. The data returned in that transfer is the count from before the clear.
- R8: irq_no is low exactly when some status bit and its mask bit (1 = enabled) are both 1. Status B bits 7:4 come from the external set input, and bits 3:0 are the saturation flags. Status A takes the low byte of the set input.
- R9: Writing the wide counter's low byte stages it, and writing the high byte loads both halves. Reading the low byte snapshots the high byte, and later reads of address 1 return that snapshot.
- R10: Counters saturate at all-ones. An increment at saturation sets status B bit 0 for the wide counter and bit k+1 for narrow counter k.
- R11: Writes to addresses 11..15 change nothing, and reads from them return 0.
- R12: After reset all registers and counters are 0, irq_no is high and data-out is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| cs_ni | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| inc_w_i | input | 1 | Wide counter increment strobe |
| inc_n_i | input | 3 | Narrow counter increment strobes |
| stat_set_i | input | 16 | Status set strobes, [7:0] status A, [15:8] status B |
| stat_live_i | input | 16 | Condition still present, same layout |
| ctrl_a_o | output | 8 | Control A register |
| ctrl_b_o | output | 8 | Control B register |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The assertions assume that the serial pins change only between sampling points, with each serial half-period lasting several block clocks. They also assume that increments never coincide with a load of the same counter. The bench drives sclk, cs and data on the falling block clock, holds every serial level for six block cycles, and gives chip select setup and hold margins around each transfer. Register values are swept through an arithmetic sequence. Counter presets are placed one step below saturation so that the increment, saturation and wrap cases are hit directly.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int N_NARROW = 3;
  localparam int WIDE_W   = 2 * BYTE_W;
  localparam int N_BANK   = 2;
  localparam int ACR_BIT  = 4;

  localparam logic [ADDR_W-1:0] A_WLO = 4'd0;
  localparam logic [ADDR_W-1:0] A_WHI = 4'd1;
  localparam logic [ADDR_W-1:0] A_N0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_STA = 4'd5;
  localparam logic [ADDR_W-1:0] A_MKA = 4'd6;
  localparam logic [ADDR_W-1:0] A_STB = 4'd7;
  localparam logic [ADDR_W-1:0] A_MKB = 4'd8;
  localparam logic [ADDR_W-1:0] A_CTA = 4'd9;
  localparam logic [ADDR_W-1:0] A_CTB = 4'd10;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_IDLE} phase_e;
endpackage

// File: rtl/sreg_serial.sv
module sreg_serial
  import sreg_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  input  logic              tx_load_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              tx_en_i,
  output logic              cs_idle_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sdo_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_N:0] sclk_p, cs_p, sdi_p;
  logic sclk_s, sclk_d, sdi_s, rise, fall;
  logic [CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p <= '1;
      cs_p   <= '1;
      sdi_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_N-1:0], sclk_i};
      cs_p   <= {cs_p[SYNC_N-1:0], cs_ni};
      sdi_p  <= {sdi_p[SYNC_N-1:0], sdi_i};
    end
  end

  assign sclk_s    = sclk_p[SYNC_N-1];
  assign sclk_d    = sclk_p[SYNC_N];
  assign sdi_s     = sdi_p[SYNC_N-1];
  assign cs_idle_o = cs_p[SYNC_N-1];
  assign rise      = sclk_s & ~sclk_d;
  assign fall      = ~sclk_s & sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (cs_idle_o) begin
        bit_cnt <= '0;
      end else if (rise) begin
        rx_sh   <= {sdi_s, rx_sh[BYTE_W-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          rx_valid_o <= 1'b1;
          rx_byte_o  <= {sdi_s, rx_sh[BYTE_W-1:1]};
        end
      end
    end
  end

  // output shifts on the falling edge only while a read is in progress
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh <= '0;
      sdo_o <= 1'b0;
    end else if (cs_idle_o) begin
      sdo_o <= 1'b0;
    end else if (tx_load_i) begin
      tx_sh <= tx_byte_i;
    end else if (fall && tx_en_i) begin
      sdo_o <= tx_sh[0];
      tx_sh <= {1'b0, tx_sh[BYTE_W-1:1]};
    end
  end
endmodule

// File: rtl/sreg_cnt.sv
module sreg_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] q_o,
  output logic         sat_evt_o
);
  logic full;
  assign full      = &q_o;
  assign sat_evt_o = inc_i & full & ~ld_i & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (ld_i)      q_o <= ld_val_i;
    else if (clr_i)     q_o <= W'(inc_i);  // keep an event that lands on the clear
    else if (inc_i && !full) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/sreg_stat.sv
module sreg_stat #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] live_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (rd_clr_i) q_o <= (q_o & live_i) | set_i;
    else               q_o <= q_o | set_i;
  end
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       cs_ni,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  input  logic                       inc_w_i,
  input  logic [N_NARROW-1:0]        inc_n_i,
  input  logic [N_BANK*BYTE_W-1:0]   stat_set_i,
  input  logic [N_BANK*BYTE_W-1:0]   stat_live_i,
  output logic [BYTE_W-1:0]          ctrl_a_o,
  output logic [BYTE_W-1:0]          ctrl_b_o,
  output logic                       irq_no
);
  localparam int SAT_PAD = BYTE_W - 1 - N_NARROW;

  logic cs_idle, rx_valid, tx_load, cmd_rd, wr_en, acr_clr, ld_w, sat_w;
  logic [BYTE_W-1:0] rx_byte, rd_data, lo_hold_q, hi_snap_q, ctrl_a_q, ctrl_b_q;
  logic [ADDR_W-1:0] addr_q, rd_addr;
  logic burst_q;
  phase_e phase_q;
  logic [N_BANK-1:0][BYTE_W-1:0] stat_q, mask_q;
  logic [N_BANK-1:0] stat_clr;
  logic [N_BANK*BYTE_W-1:0] stat_set;
  logic [WIDE_W-1:0] cnt_w, sh_w_q, src_w;
  logic [N_NARROW-1:0][BYTE_W-1:0] cnt_n, sh_n_q, src_n;
  logic [N_NARROW-1:0] ld_n, sat_n;

  sreg_serial #(.SYNC_N(SYNC_N)) u_ser (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .sdi_i,
    .tx_load_i(tx_load), .tx_byte_i(rd_data), .tx_en_i(phase_q == PH_RD),
    .cs_idle_o(cs_idle), .rx_valid_o(rx_valid), .rx_byte_o(rx_byte), .sdo_o
  );

  assign cmd_rd  = rx_valid && phase_q == PH_CMD && rx_byte[0];
  assign wr_en   = rx_valid && phase_q == PH_WR;
  assign rd_addr = (phase_q == PH_CMD) ? rx_byte[ADDR_W:1] : addr_q + 1'b1;
  assign tx_load = cmd_rd || (rx_valid && phase_q == PH_RD && burst_q && addr_q != '1);
  assign acr_clr = cmd_rd && ctrl_a_q[ACR_BIT];
  assign sdo_oe_o = !cs_idle && phase_q == PH_RD;

  // a read command sees live counters; the rest of its transfer sees the shadow
  assign src_w = cmd_rd ? cnt_w : sh_w_q;
  assign src_n = cmd_rd ? cnt_n : sh_n_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_WLO) rd_data = src_w[BYTE_W-1:0];
    if (rd_addr == A_WHI) rd_data = hi_snap_q;
    for (int k = 0; k < N_NARROW; k++)
      if (rd_addr == A_N0 + ADDR_W'(k)) rd_data = src_n[k];
    if (rd_addr == A_STA) rd_data = stat_q[0];
    if (rd_addr == A_MKA) rd_data = mask_q[0];
    if (rd_addr == A_STB) rd_data = stat_q[1];
    if (rd_addr == A_MKB) rd_data = mask_q[1];
    if (rd_addr == A_CTA) rd_data = ctrl_a_q;
    if (rd_addr == A_CTB) rd_data = ctrl_b_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      addr_q  <= '0;
      burst_q <= 1'b0;
    end else if (cs_idle) begin
      phase_q <= PH_CMD;
      burst_q <= 1'b0;
    end else if (rx_valid) begin
      unique case (phase_q)
        PH_CMD: begin
          addr_q  <= rx_byte[ADDR_W:1];
          burst_q <= rx_byte[BYTE_W-1] && rx_byte[ADDR_W:1] == A_WLO;
          phase_q <= rx_byte[0] ? PH_RD : PH_WR;
        end
        PH_WR, PH_RD: begin
          if (burst_q && addr_q != '1) addr_q <= addr_q + 1'b1;
          else phase_q <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_hold_q <= '0;
      hi_snap_q <= '0;
      mask_q    <= '0;
      ctrl_a_q  <= '0;
      ctrl_b_q  <= '0;
      sh_w_q    <= '0;
      sh_n_q    <= '0;
    end else begin
      if (cmd_rd) begin
        sh_w_q <= cnt_w;
        sh_n_q <= cnt_n;
      end
      if (tx_load && rd_addr == A_WLO) hi_snap_q <= src_w[WIDE_W-1:BYTE_W];
      if (wr_en) begin
        if (addr_q == A_WLO) lo_hold_q <= rx_byte;
        if (addr_q == A_MKA) mask_q[0] <= rx_byte;
        if (addr_q == A_MKB) mask_q[1] <= rx_byte;
        if (addr_q == A_CTA) ctrl_a_q  <= rx_byte;
        if (addr_q == A_CTB) ctrl_b_q  <= rx_byte;
      end
    end
  end

  assign ld_w = wr_en && addr_q == A_WHI;

  sreg_cnt #(.W(WIDE_W)) u_cnt_w (
    .clk_i, .rst_ni, .inc_i(inc_w_i), .clr_i(acr_clr), .ld_i(ld_w),
    .ld_val_i({rx_byte, lo_hold_q}), .q_o(cnt_w), .sat_evt_o(sat_w)
  );

  for (genvar k = 0; k < N_NARROW; k++) begin : g_narrow
    assign ld_n[k] = wr_en && addr_q == A_N0 + ADDR_W'(k);
    sreg_cnt #(.W(BYTE_W)) u_cnt (
      .clk_i, .rst_ni, .inc_i(inc_n_i[k]), .clr_i(acr_clr), .ld_i(ld_n[k]),
      .ld_val_i(rx_byte), .q_o(cnt_n[k]), .sat_evt_o(sat_n[k])
    );
  end

  assign stat_set = stat_set_i | {{SAT_PAD{1'b0}}, sat_n, sat_w, {BYTE_W{1'b0}}};
  assign stat_clr[0] = cmd_rd && rx_byte[ADDR_W:1] == A_STA;
  assign stat_clr[1] = cmd_rd && rx_byte[ADDR_W:1] == A_STB;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    sreg_stat #(.W(BYTE_W)) u_stat (
      .clk_i, .rst_ni, .set_i(stat_set[b*BYTE_W +: BYTE_W]),
      .live_i(stat_live_i[b*BYTE_W +: BYTE_W]), .rd_clr_i(stat_clr[b]), .q_o(stat_q[b])
    );
  end

  assign irq_no   = ~|(stat_q & mask_q);
  assign ctrl_a_o = ctrl_a_q;
  assign ctrl_b_o = ctrl_b_q;
endmodule

// File: rtl/sreg_chk.sv
module sreg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sdo_oe_o,
  input logic        irq_no,
  input logic        rx_valid,
  input logic        burst_q,
  input logic [1:0]  stat_clr,
  input logic [15:0] stat_q,
  input logic        acr_clr,
  input logic        ld_w,
  input logic [15:0] cnt_w,
  input logic        ld_n0,
  input logic [7:0]  cnt_n0
);
  p_oe_after_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(rx_valid));

  p_stat_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr == 2'b00 |=> (stat_q & $past(stat_q)) == $past(stat_q));

  p_burst_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_q && rx_valid) |=> (stat_q & $past(stat_q)) == $past(stat_q));

  p_acr_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acr_clr && !ld_w) |=> cnt_w <= 16'd1);

  p_irq_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q == 16'h0 |-> irq_no);

  p_wide_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w == 16'hFFFF && !ld_w && !acr_clr) |=> cnt_w == 16'hFFFF);

  p_narrow_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_n0 == 8'hFF && !ld_n0 && !acr_clr) |=> cnt_n0 == 8'hFF);
endmodule

bind sreg_port sreg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sdo_oe_o(sdo_oe_o), .irq_no(irq_no),
  .rx_valid(rx_valid), .burst_q(burst_q), .stat_clr(stat_clr), .stat_q(stat_q),
  .acr_clr(acr_clr), .ld_w(ld_w), .cnt_w(cnt_w), .ld_n0(ld_n[0]), .cnt_n0(cnt_n[0])
);

// File: tb/sim_sreg_port.sv
module sim_sreg_port;
  localparam int CLK_P = 10;
  localparam int H     = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, oe, irq_n;
  logic inc_w = 1'b0;
  logic [2:0] inc_n = '0;
  logic [15:0] st_set = '0, st_live = '0;
  logic [7:0] cta, ctb;
  int n_chk = 0, n_fail = 0;
  logic oe_seen;

  always #(CLK_P/2) clk = ~clk;

  sreg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(oe), .inc_w_i(inc_w), .inc_n_i(inc_n),
    .stat_set_i(st_set), .stat_live_i(st_live), .ctrl_a_o(cta), .ctrl_b_o(ctb),
    .irq_no(irq_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      sdi = tx[i]; sclk = 1'b0; hold(H);
      rx[i] = sdo;
      if (oe) oe_seen = 1'b1;
      sclk = 1'b1; hold(H);
    end
  endtask

  task automatic cs_on();
    oe_seen = 1'b0; cs_n = 1'b0; hold(6);
  endtask

  task automatic cs_off();
    hold(6); cs_n = 1'b1; hold(8);
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
    logic [7:0] d;
    cs_on(); xbits({3'b000, a, 1'b1}, 8, d); xbits(8'h00, 8, v); cs_off();
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] v);
    logic [7:0] d;
    cs_on(); xbits({3'b000, a, 1'b0}, 8, d); xbits(v, 8, d); cs_off();
  endtask

  task automatic pulse_w(input int n);
    for (int i = 0; i < n; i++) begin inc_w = 1'b1; hold(1); inc_w = 1'b0; hold(1); end
  endtask

  task automatic pulse_n(input int k, input int n);
    for (int i = 0; i < n; i++) begin inc_n[k] = 1'b1; hold(1); inc_n[k] = 1'b0; hold(1); end
  endtask

  task automatic pulse_set(input int b);
    st_set[b] = 1'b1; hold(1); st_set[b] = 1'b0; hold(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, d;
    logic [7:0] bexp [11];
    hold(4); rst_n = 1'b1; hold(4);

    // R12 reset state
    chk("R12 irq", {15'd0, irq_n}, 16'd1);
    chk("R12 oe", {15'd0, oe}, 16'd0);
    chk("R12 ctrl", {cta, ctb}, 16'h0000);
    rd_reg(4'd6, v); chk("R12 mask", {8'd0, v}, 16'h0000);
    rd_reg(4'd0, v); chk("R12 counter", {8'd0, v}, 16'h0000);

    // R1 R2 sweep over writable registers
    for (int i = 0; i < 24; i++) begin
      logic [7:0] val;
      logic [3:0] a;
      val = 8'((i * 37 + 5) & 8'hEF);
      a = (i % 4 == 0) ? 4'd6 : (i % 4 == 1) ? 4'd8 : (i % 4 == 2) ? 4'd9 : 4'd10;
      wr_reg(a, val);
      chk("R4 oe during write", {15'd0, oe_seen}, 16'd0);
      rd_reg(a, v);
      chk("R1 R2 readback", {8'd0, v}, {8'd0, val});
      if (a == 4'd9)  chk("R2 ctrl_a port", {8'd0, cta}, {8'd0, val});
      if (a == 4'd10) chk("R2 ctrl_b port", {8'd0, ctb}, {8'd0, val});
    end
    wr_reg(4'd9, 8'h00); wr_reg(4'd6, 8'h00); wr_reg(4'd8, 8'h00);

    // narrow counters count and preset
    wr_reg(4'd2, 8'h10); pulse_n(0, 5);
    rd_reg(4'd2, v); chk("R10 narrow count", {8'd0, v}, 16'h0015);

    // R10 saturation
    wr_reg(4'd3, 8'hFE); pulse_n(1, 3);
    rd_reg(4'd3, v); chk("R10 narrow sat", {8'd0, v}, 16'h00FF);
    rd_reg(4'd7, v); chk("R10 sat flag narrow1", {8'd0, v}, 16'h0004);
    rd_reg(4'd7, v); chk("R5 cleared after read", {8'd0, v}, 16'h0000);
    wr_reg(4'd0, 8'hFE); wr_reg(4'd1, 8'hFF); pulse_w(3);
    rd_reg(4'd0, v); chk("R10 wide sat lo", {8'd0, v}, 16'h00FF);
    rd_reg(4'd1, v); chk("R10 wide sat hi", {8'd0, v}, 16'h00FF);
    rd_reg(4'd7, v); chk("R10 sat flag wide", {8'd0, v}, 16'h0001);

    // R9 snapshot and ordered preset
    wr_reg(4'd0, 8'hFF); wr_reg(4'd1, 8'h12);
    rd_reg(4'd0, v); chk("R9 lo", {8'd0, v}, 16'h00FF);
    pulse_w(1);
    rd_reg(4'd1, v); chk("R9 hi from snapshot", {8'd0, v}, 16'h0012);
    rd_reg(4'd0, v); chk("R9 lo after wrap", {8'd0, v}, 16'h0000);
    rd_reg(4'd1, v); chk("R9 hi new snapshot", {8'd0, v}, 16'h0013);

    // R5 R8 latch, irq, clear on read
    wr_reg(4'd6, 8'h08);
    pulse_set(3);
    chk("R8 irq asserted", {15'd0, irq_n}, 16'd0);
    rd_reg(4'd5, v); chk("R5 latched", {8'd0, v}, 16'h0008);
    chk("R8 irq released", {15'd0, irq_n}, 16'd1);
    rd_reg(4'd5, v); chk("R5 clear", {8'd0, v}, 16'h0000);
    pulse_set(2);
    chk("R8 masked bit no irq", {15'd0, irq_n}, 16'd1);
    rd_reg(4'd5, v); chk("R5 masked still latched", {8'd0, v}, 16'h0004);
    wr_reg(4'd5, 8'hFF);
    rd_reg(4'd5, v); chk("R5 status write ignored", {8'd0, v}, 16'h0000);

    // R5 condition still present
    st_live[6] = 1'b1; pulse_set(6);
    rd_reg(4'd5, v); chk("R5 live read1", {8'd0, v}, 16'h0040);
    rd_reg(4'd5, v); chk("R5 live read2", {8'd0, v}, 16'h0040);
    st_live[6] = 1'b0;
    rd_reg(4'd5, v); chk("R5 live dropped", {8'd0, v}, 16'h0040);
    rd_reg(4'd5, v); chk("R5 then cleared", {8'd0, v}, 16'h0000);
    // status B external bit
    pulse_set(13); wr_reg(4'd8, 8'h20);
    chk("R8 bank B irq", {15'd0, irq_n}, 16'd0);
    rd_reg(4'd7, v); chk("R8 bank B bit", {8'd0, v}, 16'h0020);
    chk("R8 bank B release", {15'd0, irq_n}, 16'd1);
    wr_reg(4'd8, 8'h00); wr_reg(4'd6, 8'h00);

    // R7 auto counter reset
    wr_reg(4'd4, 8'h05); wr_reg(4'd9, 8'h10);
    rd_reg(4'd4, v); chk("R7 pre-clear value", {8'd0, v}, 16'h0005);
    rd_reg(4'd4, v); chk("R7 cleared", {8'd0, v}, 16'h0000);
    wr_reg(4'd2, 8'h33);
    rd_reg(4'd6, v);
    rd_reg(4'd2, v); chk("R7 any read clears", {8'd0, v}, 16'h0000);
    wr_reg(4'd9, 8'h00);

    // R3 burst write then burst read, R6 burst does not clear status
    bexp = '{8'h34, 8'h12, 8'hA1, 8'hA2, 8'hA3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5A};
    cs_on(); xbits(8'h80, 8, d);
    for (int a = 0; a < 11; a++) xbits((a == 5 || a == 7) ? 8'hFF : bexp[a], 8, d);
    cs_off();
    chk("R4 oe in burst write", {15'd0, oe_seen}, 16'd0);
    pulse_set(1);
    bexp[5] = 8'h02;
    cs_on(); xbits(8'h81, 8, d);
    for (int a = 0; a < 11; a++) begin
      xbits(8'h00, 8, v);
      chk($sformatf("R3 burst read addr %0d", a), {8'd0, v}, {8'd0, bexp[a]});
    end
    xbits(8'h00, 8, v); chk("R11 burst past end", {8'd0, v}, 16'h0000);
    cs_off();
    rd_reg(4'd5, v); chk("R6 burst kept status", {8'd0, v}, 16'h0002);

    // R3 burst flag with nonzero address: single byte only
    wr_reg(4'd6, 8'hC3);
    cs_on(); xbits(8'h8D, 8, d); xbits(8'h00, 8, v);
    chk("R3 flagged single", {8'd0, v}, 16'h00C3);
    oe_seen = 1'b0; xbits(8'h00, 8, v); cs_off();
    chk("R3 no second byte", {15'd0, oe_seen}, 16'd0);

    // R11 out of range
    rd_reg(4'd12, v); chk("R11 read zero", {8'd0, v}, 16'h0000);
    wr_reg(4'd12, 8'hFF); wr_reg(4'd15, 8'hFF);
    rd_reg(4'd6, v); chk("R11 write ignored", {8'd0, v}, 16'h00C3);

    // R4 abort mid-byte
    cs_on(); xbits(8'h0C, 8, d); xbits(8'hFF, 4, d); cs_off();
    rd_reg(4'd6, v); chk("R4 partial byte dropped", {8'd0, v}, 16'h00C3);
    cs_on(); xbits(8'h0D, 8, d); xbits(8'h00, 3, d); cs_off();
    chk("R4 oe after cs high", {15'd0, oe}, 16'd0);
    wr_reg(4'd6, 8'h3C);
    rd_reg(4'd6, v); chk("R4 port usable after abort", {8'd0, v}, 16'h003C);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule